// File: doc/BRIEF.md
# Two-Way Message Mailbox

This block lets two processors, agent A and agent B, hand each other single 32-bit words through a small register window. There is one single-entry slot per direction. Each slot is either empty or full, and it treats its sender and its recipient differently. A one-bit requester-ID input comes with every access and tells the block which agent is on the bus. From that ID the block decides whether an access to a slot is a post, a collect, or something it must ignore.

When a word is posted, the recipient's interrupt line rises, as long as that agent has enabled it. The line stays high until the recipient reads the word out. Each agent owns one interrupt-enable bit. Either agent can read a status word that shows both full flags at once.

Top module: `mbx_top`

## Requirements
- R1: Register map and encodings. Slot 0 is at offset 0x000 and carries words from A to B. Slot 1 is at 0x004 and carries words from B to A. B's enable is at 0x100, A's enable is at 0x104, and status is at 0x108. On the requester-ID input, 0 means A and 1 means B. The enable value is held in write-data bit 0.
- R2: A sender write to an empty slot stores the data and marks the slot full.
- R3: A recipient read of a full slot returns the stored word and marks the slot empty. This clears the recipient's interrupt.
- R4: A recipient write to its incoming slot changes nothing. A sender read of its outgoing slot returns 0.
- R5: A sender write to a full slot is ignored, and the earlier word is kept. A recipient read of an empty slot returns 0 and changes no state.
- R6: Reading status returns bit 0 = slot 0 full and bit 1 = slot 1 full, with all other bits 0. Writes to status have no effect.
- R7: `irq_a` equals (slot 1 full AND A's enable), and `irq_b` equals (slot 0 full AND B's enable). Setting an enable while a word is pending raises the line in the cycle after the enable write.
- R8: A write by one agent to the other agent's enable is ignored, and a read of it returns 0. An agent reading its own enable gets the bit in bit 0.
- R9: `rdata` is registered. It holds the value for a read strobe in the cycle after that strobe, and it is 0 in a cycle after no read strobe. Unmapped offsets read as 0 and ignore writes.
- R10: A synchronous active-high reset empties both slots, clears both enables, and drives both interrupts low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_id | input | 1 | Requester: 0 = agent A, 1 = agent B |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq_a | output | 1 | Interrupt to agent A |
| irq_b | output | 1 | Interrupt to agent B |

## Verification
The bench targets the cases where role matters.
- A second post to a full slot must not overwrite the first word; a design that ignored the full flag would lose the message.
- A recipient write must not fill the slot, and a sender read must not leak the word or drain the slot; a design that ignored the requester ID would do either.
- A late enable on a pending word must raise the interrupt. A design that fired the interrupt only on the post edge would leave the word unsignalled forever.
- Cross-agent enable writes must not move the other agent's line.

Random mixes of roles, offsets and strobes are scored against a bench model at every step.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned NUM_AGENTS = 2;
  localparam int unsigned OFF_SLOT0  = 'h000;
  localparam int unsigned OFF_SLOT1  = 'h004;
  localparam int unsigned OFF_EN_B   = 'h100;
  localparam int unsigned OFF_EN_A   = 'h104;
  localparam int unsigned OFF_STATUS = 'h108;

  typedef enum logic {AGENT_A = 1'b0, AGENT_B = 1'b1} agent_e;

  // slot g is posted by agent g
  function automatic int unsigned slot_off(input int g);
    return (g == 0) ? OFF_SLOT0 : OFF_SLOT1;
  endfunction

  // enable of agent g
  function automatic int unsigned en_off(input int g);
    return (g == 0) ? OFF_EN_A : OFF_EN_B;
  endfunction
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int DATA_W = 32,
  parameter bit SENDER = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              req_id,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              full,
  output logic [DATA_W-1:0] rd_val
);
  logic [DATA_W-1:0] word_q;
  logic              full_q;
  logic              is_sender, post, collect;

  assign is_sender = (req_id == SENDER);
  assign post      = sel && wr_en && is_sender && !full_q;
  assign collect   = sel && rd_en && !is_sender && full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (post) begin
      full_q <= 1'b1;
    end else if (collect) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (post) word_q <= wdata;
  end

  assign full   = full_q;
  assign rd_val = (!is_sender && full_q) ? word_q : '0;

  assert_post_fills_R2: assert property (@(posedge clk) disable iff (rst)
    (sel && wr_en && is_sender && !full) |=> (full && word_q == $past(wdata)));
  assert_collect_empties_R3: assert property (@(posedge clk) disable iff (rst)
    (sel && rd_en && !is_sender && full) |=> !full);
  assert_recip_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (sel && wr_en && !is_sender && !rd_en) |=> ($stable(full) && $stable(word_q)));
  assert_full_keeps_word_R5: assert property (@(posedge clk) disable iff (rst)
    (sel && wr_en && is_sender && full) |=> (full && $stable(word_q)));
endmodule

// File: rtl/mbx_irq_en.sv
module mbx_irq_en #(
  parameter int DATA_W = 32,
  parameter bit OWNER  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              req_id,
  input  logic              wr_en,
  input  logic              wbit,
  output logic              en,
  output logic [DATA_W-1:0] rd_val
);
  logic en_q;
  logic owner_hit;

  assign owner_hit = (req_id == OWNER);

  always_ff @(posedge clk) begin
    if (rst)                       en_q <= 1'b0;
    else if (sel && wr_en && owner_hit) en_q <= wbit;
  end

  assign en     = en_q;
  assign rd_val = owner_hit ? {{(DATA_W-1){1'b0}}, en_q} : '0;

  assert_foreign_en_write_R8: assert property (@(posedge clk) disable iff (rst)
    (sel && wr_en && !owner_hit) |=> $stable(en));
endmodule

// File: rtl/mbx_top.sv
module mbx_top #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_id,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_a,
  output logic              irq_b
);
  import mbx_pkg::*;
  localparam int NA = NUM_AGENTS;

  logic [NA-1:0]     slot_sel, en_sel, full, en;
  logic [DATA_W-1:0] slot_rd [NA];
  logic [DATA_W-1:0] en_rd   [NA];
  logic              stat_sel;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  for (genvar g = 0; g < NA; g++) begin : g_agent
    assign slot_sel[g] = (addr == ADDR_W'(slot_off(g)));
    assign en_sel[g]   = (addr == ADDR_W'(en_off(g)));

    mbx_slot #(.DATA_W(DATA_W), .SENDER(g[0])) u_slot (
      .clk(clk), .rst(rst), .sel(slot_sel[g]), .req_id(req_id),
      .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
      .full(full[g]), .rd_val(slot_rd[g])
    );

    mbx_irq_en #(.DATA_W(DATA_W), .OWNER(g[0])) u_en (
      .clk(clk), .rst(rst), .sel(en_sel[g]), .req_id(req_id),
      .wr_en(wr_en), .wbit(wdata[0]), .en(en[g]), .rd_val(en_rd[g])
    );
  end

  assign stat_sel = (addr == ADDR_W'(OFF_STATUS));

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NA; g++) begin
      if (slot_sel[g]) rd_mux = rd_mux | slot_rd[g];
      if (en_sel[g])   rd_mux = rd_mux | en_rd[g];
    end
    if (stat_sel) rd_mux = rd_mux | {{(DATA_W-NA){1'b0}}, full};
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_en) rdata_q <= '0;
    else               rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;
  // each agent is signalled by the slot the other agent posts into
  assign irq_a = full[1] & en[0];
  assign irq_b = full[0] & en[1];

  assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));
  assert_late_enable_R7: assert property (@(posedge clk) disable iff (rst)
    (en_sel[0] && wr_en && !req_id && wdata[0] && full[1] && !(slot_sel[1] && rd_en)) |=> irq_a);
  assert_status_ro_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_sel && wr_en) |=> $stable(full));
  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (!irq_a && !irq_b && rdata == '0));
endmodule

// File: tb/tb_mbx_top.sv
`timescale 1ns/1ps
module tb_mbx_top;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_id = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq_a, irq_b;

  int n_chk = 0, n_bad = 0;

  mbx_top #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .req_id(req_id), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_a(irq_a), .irq_b(irq_b)
  );

  always #2 clk = ~clk;

  // model: index 0 = A, 1 = B; slot g is posted by agent g
  logic          m_full [2];
  logic [DW-1:0] m_word [2];
  logic          m_en   [2];

  function automatic logic [DW-1:0] exp_read(input logic id, input logic [AW-1:0] a);
    case (a)
      12'h000: return (id == 1'b1 && m_full[0]) ? m_word[0] : '0;
      12'h004: return (id == 1'b0 && m_full[1]) ? m_word[1] : '0;
      12'h104: return (id == 1'b0) ? {31'b0, m_en[0]} : '0;
      12'h100: return (id == 1'b1) ? {31'b0, m_en[1]} : '0;
      12'h108: return {30'b0, m_full[1], m_full[0]};
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one access: drive at negedge, sample at following negedge
  task automatic access(input logic id, input logic rd, input logic wr,
                        input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    logic [DW-1:0] er;
    er = rd ? exp_read(id, a) : '0;
    req_id = id; rd_en = rd; wr_en = wr; addr = a; wdata = d;
    @(posedge clk);
    // model update
    if (a == 12'h000 || a == 12'h004) begin
      int s = (a == 12'h000) ? 0 : 1;
      if (wr && id == s[0] && !m_full[s]) begin m_full[s] = 1'b1; m_word[s] = d; end
      else if (rd && id != s[0] && m_full[s]) m_full[s] = 1'b0;
    end
    if (wr && a == 12'h104 && id == 1'b0) m_en[0] = d[0];
    if (wr && a == 12'h100 && id == 1'b1) m_en[1] = d[0];
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk({tag, " R9 rdata"}, rdata, er);
    chk({tag, " R7 irq_a"}, {31'b0, irq_a}, {31'b0, m_full[1] & m_en[0]});
    chk({tag, " R7 irq_b"}, {31'b0, irq_b}, {31'b0, m_full[0] & m_en[1]});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [AW-1:0] offs [6];
    offs[0] = 12'h000; offs[1] = 12'h004; offs[2] = 12'h100;
    offs[3] = 12'h104; offs[4] = 12'h108; offs[5] = 12'h02c;
    for (int i = 0; i < 2; i++) begin m_full[i] = 0; m_word[i] = '0; m_en[i] = 0; end
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10 irq_a", {31'b0, irq_a}, '0);
    chk("R10 irq_b", {31'b0, irq_b}, '0);
    chk("R10 rdata", rdata, '0);
    rst = 1'b0;
    @(negedge clk);
    access(1'b0, 1, 0, 12'h108, '0, "R10 status empty");
    // R2 post A->B, no enable yet
    access(1'b0, 0, 1, 12'h000, 32'hCAFE_0001, "R2 post");
    // R5 second post kept out
    access(1'b0, 0, 1, 12'h000, 32'hDEAD_BEEF, "R5 full post");
    // R4 recipient write, sender read
    access(1'b1, 0, 1, 12'h000, 32'h1111_2222, "R4 recip write");
    access(1'b0, 1, 0, 12'h000, '0, "R4 sender read");
    // R6 status and write to it
    access(1'b1, 0, 1, 12'h108, 32'hFFFF_FFFF, "R6 status write");
    access(1'b1, 1, 0, 12'h108, '0, "R6 status read");
    // R8 cross-agent enable write/read
    access(1'b0, 0, 1, 12'h100, 32'h1, "R8 foreign en write");
    access(1'b0, 1, 0, 12'h100, '0, "R8 foreign en read");
    // R7 late enable raises irq_b at once
    access(1'b1, 0, 1, 12'h100, 32'h1, "R7 late enable");
    access(1'b1, 1, 0, 12'h100, '0, "R8 own en read");
    // R3 collect
    access(1'b1, 1, 0, 12'h000, '0, "R3 collect");
    // R5 read of empty slot
    access(1'b1, 1, 0, 12'h000, '0, "R5 empty read");
    // reverse direction with R1 map
    access(1'b0, 0, 1, 12'h104, 32'h1, "R1 en A");
    access(1'b1, 0, 1, 12'h004, 32'h0BAD_F00D, "R1 post B->A");
    access(1'b0, 1, 0, 12'h004, '0, "R3 collect A");
    // R9 unmapped
    access(1'b0, 0, 1, 12'h02c, 32'h5, "R9 unmapped write");
    access(1'b0, 1, 0, 12'h02c, '0, "R9 unmapped read");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic id, rd, wr;
      logic [AW-1:0] a;
      id = 1'($urandom);
      rd = 1'($urandom);
      wr = 1'($urandom);
      a  = offs[$urandom_range(5)];
      access(id, rd, wr, a, $urandom, "R1 random");
    end
    // R10: reset mid-run
    access(1'b0, 0, 1, 12'h004, '0, "R10 prep");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 2; i++) begin m_full[i] = 0; m_en[i] = 0; end
    chk("R10 irq_a after reset", {31'b0, irq_a}, '0);
    chk("R10 irq_b after reset", {31'b0, irq_b}, '0);
    access(1'b1, 1, 0, 12'h108, '0, "R10 status cleared");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule